// File: doc/BRIEF.md
# Readout Frame Sequence Checker

This block watches the frames of one trigger event from a pixel detector readout. Each frame is a run of 32-bit words. The first word of a frame is its header, and a type code in that header names the frame kind. An event is expected to arrive in a fixed nesting order:

1. A trigger frame.
2. A concentrator start frame.
3. One or more module groups. Each group is a module start frame, then pixel or empty frames, then a module end frame.
4. A concentrator end frame.

The checker looks at every header and every count word as the words pass. It checks the following:

- the position of each frame kind within the event;
- that the opening and closing of concentrator and module frames pair up;
- that identifiers and low trigger numbers agree between frames;
- that the word counts in the end frames match the words seen;
- that the number of modules seen matches the port mask in the concentrator start;
- the CRC verdict that arrives with each frame.

Every violation sets its own sticky flag. The flag vector is final when the frame marked as last in the event ends. That cycle is followed by a one-cycle `evt_done` pulse. Checking the CRC itself and decoding pixels are left to other logic.

Frame words enter with `frm_vld`. `frm_sof` marks the header word. `frm_eof` marks the final word, and `frm_crc_ok` is read on that word. `frm_last` on that same word closes the event. Idle cycles may fall anywhere.

Top module: `frame_seq_checker`

## Requirements
- R1: The frame type is header bits 30:27. Default codes: pixel data 0, empty 1, trigger 2, concentrator start 3, concentrator end 4, module start 5, module end 6. Any other code sets flag bit 13 (unexpected type).
- R2: Wrong frame kinds by position set these bits. A first frame of an event that is not a trigger sets bit 0. A second frame that is not a concentrator start sets bit 1. A third frame that is not a module start sets bit 2.
- R3: At event end, a concentrator that was opened but never closed sets bit 3. A concentrator end arriving while no concentrator is open sets bit 4.
- R4: A module end while no module is open sets bit 5. A module still open when a module start, a concentrator end or the event end arrives sets bit 6.
- R5: The concentrator identifier (bits 24:21) of the end frame must equal that of the start frame, or bit 7 is set.
- R6: The module identifier (bits 25:20) of the end frame must equal that of the start frame, or bit 8 is set. The value 0x3F in either frame sets bit 9.
- R7: The second word of the concentrator end must equal the number of 32-bit words received from the concentrator start header up to the concentrator end header, excluding that header. Otherwise bit 10 is set. A missing second word also sets bit 10.
- R8: The second word of the module end must equal twice the number of 32-bit words from the module start header up to the module end header, excluding that header. Otherwise bit 11 is set.
- R9: Header bit 31 set in a module end frame sets bit 12. That bit does not alter the type decode.
- R10: A pixel or empty frame arriving while no module is open sets bit 14.
- R11: At the concentrator end, the number of module starts seen must equal the population count of the port mask in concentrator start bits 20:16. Otherwise bit 15 is set.
- R12: A frame whose final word carries `frm_crc_ok` low sets bit 16. Sequence tracking goes on unchanged.
- R13: The low trigger number (bits 15:0) in any concentrator or module start or end header must equal the one in the event's trigger frame, or bit 17 is set.
- R14: After reset, all flags are 0 and `evt_done` is low. Flags are sticky and clear on the first header of the next event. `evt_done` is high for exactly the one cycle after the final word of the last frame, and the flags hold the event's result in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_vld | input | 1 | A frame word is present |
| frm_sof | input | 1 | The word is a frame header |
| frm_eof | input | 1 | The word is the final word of its frame |
| frm_last | input | 1 | With `frm_eof`, the frame is the last of the event |
| frm_crc_ok | input | 1 | CRC verdict for the frame, read on its final word |
| frm_word | input | 32 | Frame word |
| err_flags | output | 18 | Sticky error flags, bit positions as in the requirements |
| evt_done | output | 1 | One-cycle pulse when the event result is final |

## Verification
The bench builds the block with its default type codes and a 16-bit word counter, so an event of a few dozen words covers every rule.

It builds well-formed events with one to five modules and matching port masks, plus an event with no module at all. It then builds one event per fault kind, with the fault landing on a chosen frame. It also sweeps every undefined type code through the middle of a module.

The expected flag vector comes from the fault's definition. The expected word counts are counted arithmetically as the bench emits words. Periodic idle cycles within the stream show that gaps leave the counts and positions undisturbed.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    localparam int NFLAG = 18;

    localparam int F_TRG_FIRST   = 0;
    localparam int F_CST_SECOND  = 1;
    localparam int F_MST_THIRD   = 2;
    localparam int F_CEND_MISS   = 3;
    localparam int F_CEND_DBL    = 4;
    localparam int F_MEND_NOSTRT = 5;
    localparam int F_MST_NOEND   = 6;
    localparam int F_CID_MM      = 7;
    localparam int F_MID_MM      = 8;
    localparam int F_MID_BAD     = 9;
    localparam int F_CWC         = 10;
    localparam int F_MWC         = 11;
    localparam int F_HDR_ERR     = 12;
    localparam int F_UNEXP       = 13;
    localparam int F_OUTSIDE     = 14;
    localparam int F_PORTS       = 15;
    localparam int F_CRC         = 16;
    localparam int F_TNR_MM      = 17;

    typedef struct packed {
        logic        is_trg;
        logic        is_cst;
        logic        is_cend;
        logic        is_mst;
        logic        is_mend;
        logic        is_data;
        logic        is_unexp;
        logic        err_mark;
        logic [3:0]  con_id;
        logic [4:0]  port_mask;
        logic [5:0]  mod_id;
        logic [15:0] tnr;
    } hdr_t;

endpackage

// File: rtl/fsc_decode.sv
module fsc_decode #(
    parameter logic [3:0] T_DATA  = 4'd0,
    parameter logic [3:0] T_EMPTY = 4'd1,
    parameter logic [3:0] T_TRG   = 4'd2,
    parameter logic [3:0] T_CST   = 4'd3,
    parameter logic [3:0] T_CEND  = 4'd4,
    parameter logic [3:0] T_MST   = 4'd5,
    parameter logic [3:0] T_MEND  = 4'd6
) (
    input  logic [31:0]     word,
    output fsc_pkg::hdr_t   h
);
    logic [3:0] ty;

    always_comb begin
        ty          = word[30:27];
        h.is_trg    = (ty == T_TRG);
        h.is_cst    = (ty == T_CST);
        h.is_cend   = (ty == T_CEND);
        h.is_mst    = (ty == T_MST);
        h.is_mend   = (ty == T_MEND);
        h.is_data   = (ty == T_DATA) || (ty == T_EMPTY);
        h.is_unexp  = !(h.is_trg || h.is_cst || h.is_cend || h.is_mst ||
                        h.is_mend || h.is_data);
        h.err_mark  = word[31];
        h.con_id    = word[24:21];
        h.port_mask = word[20:16];
        h.mod_id    = word[25:20];
        h.tnr       = word[15:0];
    end
endmodule

// File: rtl/fsc_tracker.sv
module fsc_tracker #(
    parameter int CNT_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frm_vld,
    input  logic                      frm_sof,
    input  logic                      frm_eof,
    input  logic                      frm_last,
    input  logic                      frm_crc_ok,
    input  logic [31:0]               frm_word,
    input  fsc_pkg::hdr_t             h,
    output logic [fsc_pkg::NFLAG-1:0] flags,
    output logic                      done
);
    import fsc_pkg::*;

    localparam logic [5:0] MID_BAD = 6'h3F;

    typedef struct packed {
        logic [1:0]       fidx;
        logic [1:0]       wpos;
        logic             con_open;
        logic             con_seen;
        logic             mod_open;
        logic             cmp_con;
        logic             cmp_mod;
        logic             trg_seen;
        logic [3:0]       con_id;
        logic [5:0]       mod_id;
        logic [15:0]      tnr;
        logic [4:0]       pmask;
        logic [3:0]       mod_cnt;
        logic [CNT_W-1:0] con_words;
        logic [CNT_W-1:0] mod_words;
        logic [NFLAG-1:0] flags;
        logic             done;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (frm_vld) begin
            if (frm_sof) begin
                if (st_q.fidx == 2'd0) st_d.flags = '0;
                case (st_q.fidx)
                    2'd0:    if (!h.is_trg) st_d.flags[F_TRG_FIRST]  = 1'b1;
                    2'd1:    if (!h.is_cst) st_d.flags[F_CST_SECOND] = 1'b1;
                    2'd2:    if (!h.is_mst) st_d.flags[F_MST_THIRD]  = 1'b1;
                    default: ;
                endcase
                if (st_q.fidx != 2'd3) st_d.fidx = st_q.fidx + 2'd1;
                st_d.wpos    = 2'd0;
                st_d.cmp_con = 1'b0;
                st_d.cmp_mod = 1'b0;
                if ((h.is_cst || h.is_cend || h.is_mst || h.is_mend) &&
                    st_q.trg_seen && (h.tnr != st_q.tnr))
                    st_d.flags[F_TNR_MM] = 1'b1;
                if (st_q.con_open) st_d.con_words = st_q.con_words + 1'b1;
                if (st_q.mod_open) st_d.mod_words = st_q.mod_words + 1'b1;

                if (h.is_trg) begin
                    st_d.trg_seen = 1'b1;
                    st_d.tnr      = h.tnr;
                end else if (h.is_cst) begin
                    st_d.con_open  = 1'b1;
                    st_d.con_seen  = 1'b1;
                    st_d.con_words = CNT_W'(1);
                    st_d.con_id    = h.con_id;
                    st_d.pmask     = h.port_mask;
                    st_d.mod_cnt   = '0;
                end else if (h.is_cend) begin
                    if (st_q.mod_open) begin
                        st_d.flags[F_MST_NOEND] = 1'b1;
                        st_d.mod_open           = 1'b0;
                    end
                    if (st_q.con_open) begin
                        st_d.cmp_con   = 1'b1;
                        st_d.con_words = st_q.con_words;
                        st_d.con_open  = 1'b0;
                        if (h.con_id != st_q.con_id) st_d.flags[F_CID_MM] = 1'b1;
                        if ({28'd0, st_q.mod_cnt} != 32'($countones(st_q.pmask)))
                            st_d.flags[F_PORTS] = 1'b1;
                    end else begin
                        st_d.flags[F_CEND_DBL] = 1'b1;
                    end
                end else if (h.is_mst) begin
                    if (st_q.mod_open) st_d.flags[F_MST_NOEND] = 1'b1;
                    if (h.mod_id == MID_BAD) st_d.flags[F_MID_BAD] = 1'b1;
                    st_d.mod_open  = 1'b1;
                    st_d.mod_words = CNT_W'(1);
                    st_d.mod_id    = h.mod_id;
                    if (st_q.mod_cnt != 4'hF) st_d.mod_cnt = st_q.mod_cnt + 4'd1;
                end else if (h.is_mend) begin
                    if (h.mod_id == MID_BAD) st_d.flags[F_MID_BAD] = 1'b1;
                    if (h.err_mark) st_d.flags[F_HDR_ERR] = 1'b1;
                    if (st_q.mod_open) begin
                        st_d.cmp_mod   = 1'b1;
                        st_d.mod_words = st_q.mod_words;
                        st_d.mod_open  = 1'b0;
                        if (h.mod_id != st_q.mod_id) st_d.flags[F_MID_MM] = 1'b1;
                    end else begin
                        st_d.flags[F_MEND_NOSTRT] = 1'b1;
                    end
                end else if (h.is_data) begin
                    if (!st_q.mod_open) st_d.flags[F_OUTSIDE] = 1'b1;
                end else begin
                    st_d.flags[F_UNEXP] = 1'b1;
                end
            end else begin
                if (st_q.con_open) st_d.con_words = st_q.con_words + 1'b1;
                if (st_q.mod_open) st_d.mod_words = st_q.mod_words + 1'b1;
                if (st_q.wpos == 2'd0) begin
                    if (st_q.cmp_con && (frm_word != 32'(st_q.con_words)))
                        st_d.flags[F_CWC] = 1'b1;
                    if (st_q.cmp_mod && (frm_word != 32'({st_q.mod_words, 1'b0})))
                        st_d.flags[F_MWC] = 1'b1;
                    st_d.cmp_con = 1'b0;
                    st_d.cmp_mod = 1'b0;
                end
                if (st_q.wpos != 2'd3) st_d.wpos = st_q.wpos + 2'd1;
            end

            if (frm_eof) begin
                if (!frm_crc_ok) st_d.flags[F_CRC] = 1'b1;
                if (st_d.cmp_con) st_d.flags[F_CWC] = 1'b1;
                if (st_d.cmp_mod) st_d.flags[F_MWC] = 1'b1;
                st_d.cmp_con = 1'b0;
                st_d.cmp_mod = 1'b0;
                if (frm_last) begin
                    if (st_d.con_seen && st_d.con_open) st_d.flags[F_CEND_MISS] = 1'b1;
                    if (st_d.mod_open) st_d.flags[F_MST_NOEND] = 1'b1;
                    st_d.fidx     = 2'd0;
                    st_d.con_open = 1'b0;
                    st_d.con_seen = 1'b0;
                    st_d.mod_open = 1'b0;
                    st_d.trg_seen = 1'b0;
                    st_d.mod_cnt  = '0;
                    st_d.done     = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;
    assign done  = st_q.done;

    // R1
    decode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_vld |-> $onehot({h.is_trg, h.is_cst, h.is_cend, h.is_mst,
                             h.is_mend, h.is_data, h.is_unexp}));
    // R1
    unexp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && frm_sof && h.is_unexp) |=> flags[F_UNEXP]);
    // R9
    hdr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && frm_sof && h.is_mend && h.err_mark) |=> flags[F_HDR_ERR]);
    // R12
    crc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_vld && frm_eof && !frm_crc_ok) |=> flags[F_CRC]);
    // R14
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(frm_vld && frm_eof && frm_last));
    // R14
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frm_vld && frm_sof && st_q.fidx == 2'd0)
            |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/frame_seq_checker.sv
module frame_seq_checker #(
    parameter int         CNT_W   = 16,
    parameter logic [3:0] T_DATA  = 4'd0,
    parameter logic [3:0] T_EMPTY = 4'd1,
    parameter logic [3:0] T_TRG   = 4'd2,
    parameter logic [3:0] T_CST   = 4'd3,
    parameter logic [3:0] T_CEND  = 4'd4,
    parameter logic [3:0] T_MST   = 4'd5,
    parameter logic [3:0] T_MEND  = 4'd6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frm_vld,
    input  logic                      frm_sof,
    input  logic                      frm_eof,
    input  logic                      frm_last,
    input  logic                      frm_crc_ok,
    input  logic [31:0]               frm_word,
    output logic [fsc_pkg::NFLAG-1:0] err_flags,
    output logic                      evt_done
);
    fsc_pkg::hdr_t hdr;

    fsc_decode #(
        .T_DATA (T_DATA),  .T_EMPTY(T_EMPTY), .T_TRG(T_TRG),
        .T_CST  (T_CST),   .T_CEND (T_CEND),  .T_MST(T_MST),
        .T_MEND (T_MEND)
    ) u_dec (
        .word (frm_word),
        .h    (hdr)
    );

    fsc_tracker #(.CNT_W(CNT_W)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_vld    (frm_vld),
        .frm_sof    (frm_sof),
        .frm_eof    (frm_eof),
        .frm_last   (frm_last),
        .frm_crc_ok (frm_crc_ok),
        .frm_word   (frm_word),
        .h          (hdr),
        .flags      (err_flags),
        .done       (evt_done)
    );
endmodule

// File: tb/sim_frame_seq_checker.sv
module sim_frame_seq_checker;
    import fsc_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic             frm_vld = 0, frm_sof = 0, frm_eof = 0, frm_last = 0, frm_crc_ok = 1;
    logic [31:0]      frm_word = '0;
    logic [NFLAG-1:0] err_flags;
    logic             evt_done;

    frame_seq_checker u0 (
        .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .frm_sof(frm_sof),
        .frm_eof(frm_eof), .frm_last(frm_last), .frm_crc_ok(frm_crc_ok),
        .frm_word(frm_word), .err_flags(err_flags), .evt_done(evt_done)
    );

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] sw [0:255];
    bit          ss [0:255];
    bit          se [0:255];
    bit          sc [0:255];
    int          sn;
    int          cw, mw;
    bit          cw_on, mw_on;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w, input bit s, input bit e, input bit crc);
        sw[sn] = w; ss[sn] = s; se[sn] = e; sc[sn] = crc;
        sn++;
        if (cw_on) cw++;
        if (mw_on) mw++;
    endtask

    task automatic frame(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                         input int n, input bit crc);
        push(a, 1'b1, n == 1, crc);
        if (n > 1) push(b, 1'b0, n == 2, crc);
        if (n > 2) push(c, 1'b0, 1'b1, crc);
    endtask

    function automatic logic [31:0] mk(input logic [3:0] t, input logic [10:0] fld, input logic [15:0] tn);
        return {1'b0, t, fld, tn};
    endfunction

    function automatic string rq_of(input int fault);
        case (fault)
            0: return "R1 clean";   1: return "R2 no trigger";   2: return "R2 no con start";
            3: return "R3 missing";  4: return "R3 double";       5: return "R4 R10 R11 no mod start";
            6: return "R4 no mod end"; 7: return "R5 con id";     8: return "R6 mod id";
            9: return "R6 id 3F";    10: return "R7 con count";   11: return "R8 mod count";
            12: return "R9 hdr bit"; 13: return "R1 unexpected";  14: return "R10 outside";
            15: return "R11 mask";   16: return "R12 crc";        default: return "R13 trigger nr";
        endcase
    endfunction

    task automatic gen(input int k, input int mask, input int fault, input int utype,
                       output logic [NFLAG-1:0] exp);
        logic [15:0] tn;
        logic [31:0] hd;
        logic [5:0]  id, eid;
        sn = 0; cw = 0; mw = 0; cw_on = 0; mw_on = 0;
        tn = 16'h1234 + 16'(fault);
        exp = '0;
        if (fault != 1) frame(mk(4'd2, 11'd0, tn), 32'hA5, 32'h5A, 3, 1'b1);
        if (fault != 2) begin
            cw = 0; cw_on = 1;
            frame(mk(4'd3, {2'b0, 4'd5, 5'(mask)}, tn), 32'h11, 32'h22, 3, 1'b1);
        end
        for (int i = 0; i < k; i++) begin
            id = (fault == 9 && i == 0) ? 6'h3F : 6'(10 + i);
            if (!(fault == 5 && i == 0)) begin
                mw = 0; mw_on = 1;
                frame(mk(4'd5, {1'b0, id, 4'b0}, (fault == 17 && i == 0) ? tn + 16'd1 : tn), 32'h0, 32'h0, 2, 1'b1);
            end
            frame(mk(4'd0, 11'd0, tn), 32'hC0DE, 32'hBEEF, 3, !(fault == 16 && i == 0));
            if (fault == 13 && i == 0) frame({1'b0, 4'(utype), 27'h0}, 32'h0, 32'h0, 2, 1'b1);
            mw_on = 0;
            if (!(fault == 6 && i == k - 1)) begin
                eid = (fault == 8 && i == 0) ? id + 6'd1 : id;
                hd = mk(4'd6, {1'b0, eid, 4'b0}, tn);
                if (fault == 12 && i == 0) hd[31] = 1'b1;
                frame(hd, 32'(2 * mw + ((fault == 11 && i == 0) ? 2 : 0)), 32'h0, 3, 1'b1);
            end
            if (fault == 14 && i == 0) frame(mk(4'd1, 11'd0, tn), 32'h0, 32'h0, 1, 1'b1);
        end
        cw_on = 0;
        hd = mk(4'd4, {2'b0, (fault == 7) ? 4'd6 : 4'd5, 5'b0}, tn);
        if (fault != 3) frame(hd, 32'(cw + ((fault == 10) ? 1 : 0)), 32'h0, 3, 1'b1);
        if (fault == 4) frame(hd, 32'(cw), 32'h0, 3, 1'b1);
        case (fault)
            1:  begin exp[F_TRG_FIRST] = 1; exp[F_CST_SECOND] = 1; exp[F_MST_THIRD] = 1; end
            2:  begin exp[F_CST_SECOND] = 1; exp[F_MST_THIRD] = 1; exp[F_CEND_DBL] = 1; end
            3:  exp[F_CEND_MISS] = 1;
            4:  exp[F_CEND_DBL] = 1;
            5:  begin exp[F_MST_THIRD] = 1; exp[F_OUTSIDE] = 1; exp[F_MEND_NOSTRT] = 1; exp[F_PORTS] = 1; end
            6:  exp[F_MST_NOEND] = 1;
            7:  exp[F_CID_MM] = 1;
            8:  exp[F_MID_MM] = 1;
            9:  exp[F_MID_BAD] = 1;
            10: exp[F_CWC] = 1;
            11: exp[F_MWC] = 1;
            12: exp[F_HDR_ERR] = 1;
            13: exp[F_UNEXP] = 1;
            14: exp[F_OUTSIDE] = 1;
            15: exp[F_PORTS] = 1;
            16: exp[F_CRC] = 1;
            17: exp[F_TNR_MM] = 1;
            default: ;
        endcase
        if (k == 0) exp[F_MST_THIRD] = 1;
    endtask

    task automatic run(input logic [NFLAG-1:0] exp, input string rq);
        bit early = 0;
        for (int i = 0; i < sn; i++) begin
            @(negedge clk);
            if (evt_done) early = 1;
            frm_vld = 1; frm_word = sw[i]; frm_sof = ss[i]; frm_eof = se[i];
            frm_crc_ok = sc[i]; frm_last = (i == sn - 1);
            if (i % 4 == 3 && i != sn - 1) begin
                @(negedge clk);
                if (evt_done) early = 1;
                frm_vld = 0; frm_sof = 0; frm_eof = 0; frm_last = 0;
            end
        end
        @(negedge clk);
        frm_vld = 0; frm_sof = 0; frm_eof = 0; frm_last = 0; frm_crc_ok = 1;
        chk(evt_done === 1'b1 && !early, {"R14 done pulse ", rq}, {31'd0, evt_done}, 32'd1);
        chk(err_flags === exp, rq, 32'(err_flags), 32'(exp));
        @(negedge clk);
        chk(evt_done === 1'b0, {"R14 done one cycle ", rq}, {31'd0, evt_done}, 32'd0);
        repeat (2) @(negedge clk);
        chk(err_flags === exp, {"R14 sticky ", rq}, 32'(err_flags), 32'(exp));
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [NFLAG-1:0] e;
        repeat (4) @(negedge clk);
        chk(err_flags === '0 && evt_done === 1'b0, "R14 reset", 32'(err_flags), 32'd0);
        rst_n = 1;
        @(negedge clk);
        for (int k = 0; k <= 5; k++) begin
            gen(k, (1 << k) - 1, 0, 0, e);
            run(e, (k == 0) ? "R2 no module" : "R1 R7 R8 clean");
        end
        for (int f = 1; f <= 17; f++) begin
            if (f == 13) continue;
            gen(2, (f == 15) ? 7 : 3, f, 0, e);
            run(e, rq_of(f));
            gen(3, 7, 0, 0, e);
            run(e, "R14 cleared after fault");
        end
        for (int t = 7; t <= 15; t++) begin
            gen(2, 3, 13, t, e);
            run(e, rq_of(13));
        end
        finish_run();
    end
endmodule